// File: doc/BRIEF.md
# Hybrid Static/Dynamic Branch Direction and Target Predictor

This block tells a fetch unit whether a conditional branch will be taken and where fetch should go next. It keeps two tables. The first holds a 2-bit saturating confidence counter for each tracked branch. The second records the destination each branch reached the last time it was taken. Both tables are indexed by low bits of the word address and tagged with the bits above the index.

When the branch has no counter entry, the block uses a fixed rule instead. A branch whose offset is negative, meaning it points backward, is predicted taken. A branch that points forward is predicted not taken. A taken direction is only reported if the target table also holds a destination for the branch. Otherwise fetch continues sequentially at the next word.

Lookups are combinational from registered table state. An update arrives on a separate port with the resolved direction and destination, and it takes effect at the next clock edge.

Top module: `bpred_top`

## Requirements
- R1: While `lk_valid` is low, `lk_taken` is 0. Whenever `lk_taken` is 0, `lk_target` equals `lk_pc + 4`.
- R2: When the counter table has no matching entry, the direction comes from `lk_backward`: 1 (negative offset) means taken and 0 means not taken.
- R3: When the counter table hits, only the counter decides the direction: taken when its upper bit is 1. The encoding is 00 strong-not-taken, 01 weak-not-taken, 10 weak-taken, 11 strong-taken.
- R4: Each update of a tracked branch moves its counter one step toward the outcome and saturates at 00 and at 11.
- R5: An update whose PC misses the counter table writes that slot with the new tag and a weak state: 10 if taken, 01 if not taken. This replaces any branch that aliases to the same slot.
- R6: A taken update writes its destination into the target table. A taken prediction drives the stored destination on `lk_target`.
- R7: A taken direction with no target-table hit is reported as not taken, with `lk_target = lk_pc + 4`.
- R8: When a lookup and an update touch the same slot in one cycle, the lookup reflects the state before the update.
- R9: Reset empties both tables.
- R10: A not-taken update leaves the target table unchanged.
- R11: The counter table has 64 slots, indexed by PC bits [7:2] and tagged with PC bits [31:8]. The target table has 32 slots, indexed by PC bits [6:2] and tagged with PC bits [31:7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup is a conditional branch |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_backward | input | 1 | Sign of the branch offset; 1 means it points backward |
| lk_taken | output | 1 | Predicted taken, with a known destination |
| lk_target | output | 32 | Next fetch address |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction |
| up_target | input | 32 | Resolved destination |

## Verification
A lookup and an update can meet in the same cycle on the same table slot. The lookup must then see the state from before the edge, and the new state must become visible only on the following cycle.

The bench provokes this two ways. A directed step looks up a branch in the same cycle that branch's counter is updated. A random phase drives both ports every cycle over a small set of addresses, including addresses that alias to the same slots.

A behavioural model in the bench computes each prediction from its state as it stood before that cycle's update. That prediction is compared with the outputs every cycle, before the model applies the update.

// File: rtl/bpred_pkg.sv
// bpred_pkg: shared counter type and its transition rules.
// Assumes the 2-bit encoding 00 strong-not-taken up to 11 strong-taken.
package bpred_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;

    // One saturating step toward the resolved outcome.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            default: nxt = taken ? CTR_ST  : CTR_WT;
        endcase
        return nxt;
    endfunction

    // Weak state matching the first observed outcome.
    function automatic ctr_t ctr_alloc(input logic taken);
        return taken ? CTR_WT : CTR_WNT;
    endfunction

    // Direction encoded by a counter.
    function automatic logic ctr_dir(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/bpred_hist_table.sv
// bpred_hist_table: tagged table of 2-bit direction counters.
// Reads are combinational from registered state, so a same-cycle write is
// not visible on the read port. Addresses are word addresses (PC[.. :2]).
module bpred_hist_table
    import bpred_pkg::*;
#(
    parameter int ADDR_W  = 30,
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output ctr_t              rd_ctr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_taken
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic             vld_q [ENTRIES];
    logic [TAG_W-1:0] tag_q [ENTRIES];
    ctr_t             ctr_q [ENTRIES];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic             wr_hit;
    ctr_t             wr_next;

    // Split both addresses into index and tag.
    always_comb begin
        rd_idx = rd_addr[IDX_W-1:0];
        rd_tag = rd_addr[ADDR_W-1:IDX_W];
        wr_idx = wr_addr[IDX_W-1:0];
        wr_tag = wr_addr[ADDR_W-1:IDX_W];
    end

    // Read port: hit when the slot is valid and its tag matches.
    always_comb begin
        rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_ctr = ctr_q[rd_idx];
    end

    // Next counter value: a step on a hit, a weak allocation on a miss.
    always_comb begin
        wr_hit  = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
        wr_next = wr_hit ? ctr_step(ctr_q[wr_idx], wr_taken)
                         : ctr_alloc(wr_taken);
    end

    // Storage: clear on reset, write one slot on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                ctr_q[i] <= CTR_WNT;
            end
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            tag_q[wr_idx] <= wr_tag;
            ctr_q[wr_idx] <= wr_next;
        end
    end
endmodule

// File: rtl/bpred_target_buf.sv
// bpred_target_buf: tagged table of branch destinations.
// Only taken outcomes are written. Reads are combinational from
// registered state.
module bpred_target_buf #(
    parameter int ADDR_W  = 30,
    parameter int PC_W    = 32,
    parameter int ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [PC_W-1:0]   rd_target,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PC_W-1:0]   wr_target
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic             vld_q [ENTRIES];
    logic [TAG_W-1:0] tag_q [ENTRIES];
    logic [PC_W-1:0]  tgt_q [ENTRIES];

    logic [IDX_W-1:0] rd_idx, wr_idx;

    // Index extraction for both ports.
    always_comb begin
        rd_idx = rd_addr[IDX_W-1:0];
        wr_idx = wr_addr[IDX_W-1:0];
    end

    // Read port: tag compare and destination output.
    always_comb begin
        rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_addr[ADDR_W-1:IDX_W]);
        rd_target = tgt_q[rd_idx];
    end

    // Storage: clear on reset, record the destination of a taken branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                tgt_q[i] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            tag_q[wr_idx] <= wr_addr[ADDR_W-1:IDX_W];
            tgt_q[wr_idx] <= wr_target;
        end
    end
endmodule

// File: rtl/bpred_dir_sel.sv
// bpred_dir_sel: combines the counter, the static sign rule and the target
// lookup into the final prediction. Purely combinational.
module bpred_dir_sel
    import bpred_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            lk_valid,
    input  logic            lk_backward,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            hist_hit,
    input  ctr_t            hist_ctr,
    input  logic            tgt_hit,
    input  logic [PC_W-1:0] tgt_value,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target
);
    localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(4);

    logic dir_taken;

    // Direction: the counter when tracked, otherwise backward means taken.
    always_comb begin
        dir_taken = hist_hit ? ctr_dir(hist_ctr) : lk_backward;
    end

    // Redirect only when a destination is known; otherwise go sequential.
    always_comb begin
        pred_taken  = lk_valid && dir_taken && tgt_hit;
        pred_target = pred_taken ? tgt_value : (lk_pc + SEQ_STEP);
    end
endmodule

// File: rtl/bpred_top.sv
// bpred_top: branch predictor with a tagged counter table, a tagged
// destination table and a static sign fallback. Lookups see state from
// before the current edge. Updates land at the clock edge.
// Assumes word-aligned branch addresses; PC bits [1:0] take no part in
// indexing.
module bpred_top
    import bpred_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int HIST_ENTRIES = 64,
    parameter int TGT_ENTRIES  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_backward,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_target,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_target
);
    localparam int ADDR_W = PC_W - 2;

    logic [ADDR_W-1:0] lk_addr, up_addr;
    logic              hist_hit, tgt_hit, tgt_wr;
    ctr_t              hist_ctr;
    logic [PC_W-1:0]   tgt_value;
    logic [1:0]        up_pc_unused;

    // Word addresses for both ports.
    always_comb begin
        lk_addr      = lk_pc[PC_W-1:2];
        up_addr      = up_pc[PC_W-1:2];
        up_pc_unused = up_pc[1:0];
        tgt_wr       = up_valid && up_taken;
    end

    bpred_hist_table #(
        .ADDR_W (ADDR_W),
        .ENTRIES(HIST_ENTRIES)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (lk_addr),
        .rd_hit  (hist_hit),
        .rd_ctr  (hist_ctr),
        .wr_en   (up_valid),
        .wr_addr (up_addr),
        .wr_taken(up_taken)
    );

    bpred_target_buf #(
        .ADDR_W (ADDR_W),
        .PC_W   (PC_W),
        .ENTRIES(TGT_ENTRIES)
    ) u_tgt (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (lk_addr),
        .rd_hit   (tgt_hit),
        .rd_target(tgt_value),
        .wr_en    (tgt_wr),
        .wr_addr  (up_addr),
        .wr_target(up_target)
    );

    bpred_dir_sel #(
        .PC_W(PC_W)
    ) u_sel (
        .lk_valid   (lk_valid),
        .lk_backward(lk_backward),
        .lk_pc      (lk_pc),
        .hist_hit   (hist_hit),
        .hist_ctr   (hist_ctr),
        .tgt_hit    (tgt_hit),
        .tgt_value  (tgt_value),
        .pred_taken (lk_taken),
        .pred_target(lk_target)
    );
endmodule

// File: rtl/bpred_chk.sv
// bpred_chk: port-level properties of bpred_top, attached by bind.
module bpred_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_backward,
    input logic            lk_taken,
    input logic [PC_W-1:0] lk_target,
    input logic            up_valid,
    input logic [PC_W-1:0] up_pc,
    input logic            up_taken,
    input logic [PC_W-1:0] up_target
);
    // R1: an idle lookup never predicts taken.
    assert_idle_not_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_taken);

    // R1 / R7: a not-taken result always points at the next word.
    assert_seq_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_taken |-> (lk_target == lk_pc + PC_W'(4)));

    // R9: empty tables after reset cannot yield a taken prediction.
    assert_reset_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_taken);

    // R8: with no update at the previous edge and steady lookup inputs,
    // the prediction does not move.
    assert_state_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(up_valid) && $stable(lk_valid) && $stable(lk_pc) && $stable(lk_backward))
        |-> ($stable(lk_taken) && $stable(lk_target)));
endmodule

bind bpred_top bpred_chk #(.PC_W(PC_W)) u_bpred_chk (.*);

// File: tb/bpred_top_tb_top.sv
`timescale 1ns/1ps
module bpred_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_backward, lk_taken;
    logic [31:0] lk_pc, lk_target;
    logic        up_valid, up_taken;
    logic [31:0] up_pc, up_target;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // Behavioural reference state.
    bit          h_v [64];
    int unsigned h_tag [64];
    int          h_c [64];
    bit          t_v [32];
    int unsigned t_tag [32];
    logic [31:0] t_dst [32];

    always #2 clk = ~clk;

    bpred_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_backward(lk_backward),
        .lk_taken(lk_taken), .lk_target(lk_target),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_target(up_target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < 64; i++) begin h_v[i] = 0; h_tag[i] = 0; h_c[i] = 1; end
        for (int i = 0; i < 32; i++) begin t_v[i] = 0; t_tag[i] = 0; t_dst[i] = 0; end
    endfunction

    // Compare outputs with the model, then apply the update at the edge.
    task automatic step(input bit lv, input logic [31:0] lp, input bit lb,
                        input bit uv, input logic [31:0] upc, input bit ut,
                        input logic [31:0] ud, input string tag);
        int hi, ti;
        bit hh, th, dir, exp_t;
        logic [31:0] exp_d;
        string req;
        @(negedge clk);
        lk_valid = lv; lk_pc = lp; lk_backward = lb;
        up_valid = uv; up_pc = upc; up_taken = ut; up_target = ud;
        #1;
        hi = int'(lp[7:2]); ti = int'(lp[6:2]);
        hh = h_v[hi] && (h_tag[hi] == int'(lp[31:8]));
        th = t_v[ti] && (t_tag[ti] == int'(lp[31:7]));
        dir = hh ? (h_c[hi] >= 2) : lb;
        exp_t = lv && dir && th;
        exp_d = exp_t ? t_dst[ti] : lp + 32'd4;
        if (!lv) req = "R1";
        else if (dir && !th) req = "R7";
        else if (!hh) req = "R2";
        else if (exp_t) req = "R6";
        else req = "R3";
        check({req, " ", tag, " taken"}, {31'd0, lk_taken}, {31'd0, exp_t});
        check({req, " ", tag, " target"}, lk_target, exp_d);
        @(posedge clk);
        if (uv) begin
            hi = int'(upc[7:2]); ti = int'(upc[6:2]);
            if (h_v[hi] && h_tag[hi] == int'(upc[31:8])) begin
                if (ut && h_c[hi] < 3) h_c[hi]++;
                else if (!ut && h_c[hi] > 0) h_c[hi]--;
            end else begin
                h_v[hi] = 1; h_tag[hi] = int'(upc[31:8]); h_c[hi] = ut ? 2 : 1;
            end
            if (ut) begin t_v[ti] = 1; t_tag[ti] = int'(upc[31:7]); t_dst[ti] = ud; end
        end
    endtask

    task automatic look(input logic [31:0] p, input bit b, input string tag);
        step(1, p, b, 0, 0, 0, 0, tag);
    endtask

    task automatic upd(input logic [31:0] p, input bit t, input logic [31:0] d, input string tag);
        step(0, p, 0, 1, p, t, d, tag);
    endtask

    initial begin : watchdog
        while (!done && cycles < 200000) begin @(posedge clk); cycles++; end
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<200000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        lk_valid = 0; lk_pc = 0; lk_backward = 0;
        up_valid = 0; up_pc = 0; up_taken = 0; up_target = 0;
        rst_n = 0;
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R9: empty after reset; R7 static taken without a destination.
        look(32'h100, 1, "R9 reset backward");
        look(32'h100, 0, "R9 reset forward");
        step(0, 32'h100, 1, 0, 0, 0, 0, "R1 idle");
        // R5 / R6: allocation as weak-taken plus destination.
        upd(32'h100, 1, 32'h80, "R5 alloc taken");
        look(32'h100, 0, "R6 R11 redirect");
        // R3 / R4: walk the counter down, saturate, then back up.
        upd(32'h100, 0, 32'h0, "R4 down");
        look(32'h100, 1, "R3 weak-not-taken");
        upd(32'h100, 0, 32'h0, "R4 down");
        upd(32'h100, 0, 32'h0, "R4 saturate low");
        upd(32'h100, 1, 32'h80, "R4 up");
        look(32'h100, 1, "R4 still not taken");
        upd(32'h100, 1, 32'h84, "R4 up");
        look(32'h100, 0, "R4 taken again");
        upd(32'h100, 1, 32'h84, "R4 up");
        upd(32'h100, 1, 32'h84, "R4 saturate high");
        upd(32'h100, 0, 32'h0, "R4 one down");
        look(32'h100, 0, "R4 saturation held");
        // R10 / R5: aliasing not-taken update evicts the counter only.
        upd(32'h200, 0, 32'h0, "R5 alias alloc");
        look(32'h100, 1, "R2 R10 static backward");
        look(32'h100, 0, "R2 static forward");
        look(32'h200, 1, "R3 alias not taken");
        // R8: lookup and update to the same slot in one cycle.
        upd(32'h300, 1, 32'h340, "R5 alloc");
        step(1, 32'h300, 0, 1, 32'h300, 0, 32'h0, "R8 same cycle");
        look(32'h300, 0, "R8 after edge");
        step(1, 32'h300, 0, 1, 32'h300, 0, 32'h0, "R8 same cycle down");
        look(32'h300, 0, "R8 after second edge");
        // Mixed traffic on both ports every cycle.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b;
            a = 32'h1000 + ($urandom % 20) * 4 + ($urandom % 3) * 256;
            b = 32'h1000 + ($urandom % 20) * 4 + ($urandom % 3) * 256;
            if (($urandom % 4) == 0) b = a;
            step(($urandom % 5) != 0, a, $urandom % 2,
                 ($urandom % 3) != 0, b, $urandom % 2,
                 32'h8000 + ($urandom % 64) * 4, "R8 mixed");
        end
        // R9: reset mid-run clears everything.
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        model_clear();
        look(32'h1000, 1, "R9 cleared");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule